// File: doc/BRIEF.md
# Thread Stall Countdown Timer

This unit holds one hardware thread stalled for a software-requested number of clock cycles. Software writes a cycle count through a single register-write port. The unit divides that count down to an 8-cycle granularity, loads the result into a countdown and raises a registered stall output. The stall stays high until the countdown runs out or an asynchronous trap request cuts it short. A one-cycle done pulse marks the end of every stall.

One instance serves one thread, and each instance keeps its own counter. A value below one granule still stalls the thread, for exactly one cycle. A new write during a stall replaces the remaining time and starts the 8-cycle prescaler over.

Top module: `pause_timer`

## Requirements
- R1: During and after a synchronous reset, with no write since, `stall` and `done` are both 0.
- R2: A cycle with `wr_en`=1 and `trap_req`=0 makes `stall` 1 in the following cycle.
- R3: A written value V with V>>3 = N ≥ 1 keeps `stall` high for exactly 8·N consecutive cycles, counted from the cycle after the write. The low 3 bits of V are dropped.
- R4: A written value below 8, including 0, keeps `stall` high for exactly one cycle.
- R5: `trap_req`=1 while `stall` is 1 makes `stall` 0 in the next cycle.
- R6: `trap_req` has priority over `wr_en`. A trap while idle changes nothing, and a write presented in the same cycle as a trap is discarded.
- R7: A write while `stall` is 1 reloads the countdown and restarts the prescaler. `stall` stays high without a gap, ends as R3/R4 give for the new value measured from the new write, and raises no `done` at the reload.
- R8: `done` is a one-cycle pulse in the first cycle that `stall` is 0 after any stall, whether the stall ended by expiry or by trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a pause request |
| wr_data | input | DATA_W | Requested stall length in cycles |
| trap_req | input | 1 | Disrupting trap request that aborts a stall |
| stall | output | 1 | Thread stall, registered |
| done | output | 1 | One-cycle end-of-stall pulse, registered |

## Verification
The minimum-stall property assumes that a one-granule write is not followed straight away by another write or a trap. The done-pulse and trap properties assume that the inputs are held low during reset. The stimulus drives every input on the falling edge and holds `wr_en` and `trap_req` low in reset. It allows back-to-back events only in the rewrite and trap scenarios, where the properties guard on those inputs. Random values stay below 1024, so each stall lasts at most about a thousand cycles.

// File: rtl/pause_timer_pkg.sv
package pause_timer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MIN  = 2'd1,
    ST_RUN  = 2'd2
  } pause_state_t;

  function automatic int unsigned granule_cycles(input int unsigned shift);
    return 32'd1 << shift;
  endfunction

endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int GRAN_SHIFT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  localparam int PW = (GRAN_SHIFT < 1) ? 1 : GRAN_SHIFT;
  localparam logic [PW-1:0] LAST = {PW{1'b1}};

  logic [PW-1:0] phase_q;

  generate
    if (GRAN_SHIFT == 0) begin : g_every_cycle
      assign tick = enable;
      always_ff @(posedge clk) phase_q <= '0;
    end else begin : g_divided
      assign tick = enable && (phase_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          phase_q <= '0;
        end else if (enable) begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_one
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (dec && remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign at_one = (remain_q == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_timer_pkg::*;
#(
  parameter bit DONE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic trap_req,
  input  logic load_is_zero,
  input  logic tick,
  input  logic cnt_at_one,
  output logic load,
  output logic run_en,
  output logic stall,
  output logic done
);
  pause_state_t state_q, state_d;
  logic         stall_q, done_q, end_d;

  assign load   = wr_en && !trap_req;
  assign run_en = (state_q == ST_RUN) && !wr_en && !trap_req;

  always_comb begin
    state_d = state_q;
    end_d   = 1'b0;
    if (trap_req) begin
      if (state_q != ST_IDLE) begin
        state_d = ST_IDLE;
        end_d   = 1'b1;
      end
    end else if (wr_en) begin
      state_d = load_is_zero ? ST_MIN : ST_RUN;
    end else begin
      case (state_q)
        ST_MIN: begin
          state_d = ST_IDLE;
          end_d   = 1'b1;
        end
        ST_RUN: begin
          if (tick && cnt_at_one) begin
            state_d = ST_IDLE;
            end_d   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_q <= (state_d != ST_IDLE);
      done_q  <= end_d;
    end
  end

  assign stall = stall_q;

  generate
    if (DONE_EN) begin : g_done
      assign done = done_q;
    end else begin : g_no_done
      assign done = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int DATA_W     = 16,
  parameter int GRAN_SHIFT = 3,
  parameter bit DONE_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap_req,
  output logic              stall,
  output logic              done
);
  localparam int CNT_W = DATA_W - GRAN_SHIFT;

  logic [CNT_W-1:0] load_val;
  logic             load, run_en, tick, cnt_at_one;

  assign load_val = wr_data[DATA_W-1:GRAN_SHIFT];

  pause_ctrl #(.DONE_EN(DONE_EN)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .trap_req     (trap_req),
    .load_is_zero (load_val == '0),
    .tick         (tick),
    .cnt_at_one   (cnt_at_one),
    .load         (load),
    .run_en       (run_en),
    .stall        (stall),
    .done         (done)
  );

  pause_prescaler #(.GRAN_SHIFT(GRAN_SHIFT)) presc_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (load),
    .enable (run_en),
    .tick   (tick)
  );

  pause_countdown #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .dec      (tick),
    .at_one   (cnt_at_one)
  );

endmodule

// File: rtl/pause_timer_chk.sv
module pause_timer_chk #(
  parameter int DATA_W     = 16,
  parameter int GRAN_SHIFT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              trap_req,
  input logic              stall,
  input logic              done
);
  // R2
  write_starts_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trap_req) |=> stall);

  // R4
  min_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !wr_en && !trap_req &&
     $past(wr_en && !trap_req && ((wr_data >> GRAN_SHIFT) == '0))) |=> !stall);

  // R5
  trap_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && stall) |=> !stall);

  // R6
  idle_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !stall) |=> (!stall && !done));

  // R8
  done_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!stall && $past(stall)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind pause_timer pause_timer_chk #(.DATA_W(DATA_W), .GRAN_SHIFT(GRAN_SHIFT)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .trap_req(trap_req), .stall(stall), .done(done)
);

// File: tb/pause_timer_tb.sv
`timescale 1ns/1ps
module pause_timer_tb_top;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              trap_req = 1'b0;
  logic              stall, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pause_timer #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .trap_req(trap_req), .stall(stall), .done(done)
  );

  function automatic int exp_len(input int v);
    return ((v >> 3) == 0) ? 1 : (v >> 3) * 8;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input int v);
    wr_en   = 1'b1;
    wr_data = v[DATA_W-1:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Counts stall cycles from the current negedge; ends on the first low cycle.
  task automatic measure(output int len, output int bad_done);
    len = 0;
    bad_done = 0;
    while (stall && len < 5000) begin
      len++;
      if (done) bad_done = 1;
      @(negedge clk);
    end
  endtask

  task automatic run_pause(input string req, input int v);
    int len, bd;
    do_write(v);
    check("R2", stall, 1);
    measure(len, bd);
    check(req, len, exp_len(v));
    check("R8", done, 1);
    check("R8", bd, 0);
    @(negedge clk);
    check("R8", done, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len, bd, v, k;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", stall, 0);
    check("R1", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", stall, 0);
    check("R1", done, 0);

    // Directed corner values
    run_pause("R4", 0);
    run_pause("R4", 7);
    run_pause("R3", 8);
    run_pause("R3", 15);
    run_pause("R3", 100);

    // R6: trap while idle
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    check("R6", stall, 0);
    check("R6", done, 0);

    // R6: write together with trap is discarded
    trap_req = 1'b1;
    do_write(64);
    trap_req = 1'b0;
    check("R6", stall, 0);
    check("R6", done, 0);
    @(negedge clk);
    check("R6", stall, 0);

    // R5: trap aborts a running stall
    do_write(800);
    repeat (20) @(negedge clk);
    check("R5", stall, 1);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    check("R5", stall, 0);
    check("R8", done, 1);
    @(negedge clk);
    check("R8", done, 0);

    // R5: trap aborts a minimum stall
    do_write(3);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    check("R5", stall, 0);
    check("R8", done, 1);
    @(negedge clk);

    // R7: rewrite mid-stall restarts from the new write
    do_write(160);
    repeat (29) @(negedge clk);
    do_write(43);
    check("R7", stall, 1);
    check("R7", done, 0);
    measure(len, bd);
    check("R7", len, exp_len(43));
    check("R7", bd, 0);
    check("R8", done, 1);
    @(negedge clk);

    // R7: rewrite to a small value gives one more cycle
    do_write(120);
    repeat (5) @(negedge clk);
    do_write(2);
    measure(len, bd);
    check("R7", len, 1);
    check("R7", bd, 0);
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      v = $urandom_range(0, 1023);
      if ($urandom_range(0, 3) == 0 && v >= 64) begin
        do_write(v);
        k = $urandom_range(1, 7);
        repeat (k) @(negedge clk);
        v = $urandom_range(0, 300);
        do_write(v);
        measure(len, bd);
        check("R7", len, exp_len(v));
        check("R7", bd, 0);
        @(negedge clk);
      end else begin
        run_pause((v < 8) ? "R4" : "R3", v);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule